// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block keeps the volatile position of four wipers belonging to a pair of digital potentiometers, each with two wipers. Every position is an 8-bit value that chooses one of 256 taps. A host moves a wiper through a simple pin interface. Pulling the active-low chip select low enables the block. Each high-to-low transition on the step clock pin then moves the wiper chosen by a two-pin select code by one tap. The direction pin decides whether the move is up or down.

When chip select is released, the levels on the step clock and the write-protect pin decide what happens. If both are high and the register-select field is zero, the block sends a one-cycle store request carrying the index of the chosen wiper, so that the nonvolatile store can save the position. Otherwise the block returns to standby, and the new position remains in effect. While the block is selected, it also raises a flag that keeps the shared two-wire serial bus disabled.

All pins are sampled on the system clock. A move takes effect one system clock after the step clock pin is first seen low. The nonvolatile memory, the resistor array and the analog wiper sit outside this block.

Top module: `updown_wiper_ctrl`

## Requirements
- R1: While reset is asserted, each wiper position equals its slice of `preset_i`, `store_stb_o` is 0 and `bus_off_o` is 0.
- R2: With `cs_n_i` low, a high-to-low transition of `sclk_i` while `dir_i` is 1 increases the selected wiper position by one. The new value is visible one system clock after `sclk_i` is first sampled low.
- R3: With `cs_n_i` low, a high-to-low transition of `sclk_i` while `dir_i` is 0 decreases the selected wiper position by one.
- R4: Wiper index i occupies `pos_o[8*i+7:8*i]`. The `ds_i` code maps to an index as follows: 00 selects index 0 (pot 0, wiper A); 11 selects index 1 (pot 0, wiper B); 10 selects index 2 (pot 1, wiper A); 01 selects index 3 (pot 1, wiper B). Only the selected wiper moves.
- R5: While `cs_n_i` is high, transitions on `sclk_i` leave every position unchanged.
- R6: Positions saturate. A step up at 255 leaves the value at 255, and a step down at 0 leaves it at 0.
- R7: A low-to-high transition of `cs_n_i` issues a store when three conditions hold: `sclk_i` is 1, `wp_i` is 1 and `rsel_i` is 00. The block then drives `store_stb_o` high for exactly one system clock, with `store_idx_o` set to the index from R4.
- R8: A release of `cs_n_i` with `wp_i` low, or with `rsel_i` nonzero, issues no store.
- R9: A release of `cs_n_i` with `sclk_i` low issues no store, and the moved position is kept.
- R10: `bus_off_o` is 1 one system clock after `cs_n_i` is sampled low, and 0 one system clock after it is sampled high.
- R11: A change of `dir_i` while `cs_n_i` stays low takes effect on the next falling edge of `sclk_i`.
- R12: A rising edge of `sclk_i`, or a steady level on it, does not move any wiper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; loads the presets |
| cs_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Step clock pin; a falling edge moves a wiper |
| dir_i | input | 1 | Direction: 1 up, 0 down |
| ds_i | input | 2 | Wiper select code (R4) |
| wp_i | input | 1 | Write protect; 1 permits a store |
| rsel_i | input | 2 | Register-select field; must be 00 for a store |
| preset_i | input | 32 | Recalled positions, 8 bits per wiper |
| pos_o | output | 32 | Current wiper positions, 8 bits per wiper |
| store_stb_o | output | 1 | One-cycle store request |
| store_idx_o | output | 2 | Index of the wiper to store |
| bus_off_o | output | 1 | High while the serial bus must stay disabled |

## Verification
Stepping is driven with alternating step clock levels, under both directions and all four select codes. This shows that falling edges move the wiper while rising edges and steady levels do not, and that each code reaches its own wiper slice. Runs of steps drive wipers into both limits, which separates saturation from wrap-around. Step clock toggles with chip select high, and a direction change in mid-session, show that the enable and direction are sampled at each edge. Chip select is released under four sets of conditions: step clock high and write protect high, step clock low, write protect low, and a nonzero register field. Each of these singles out one of the conditions that gate the store strobe and its index.

// File: rtl/updown_wiper_ctrl.sv
module updown_wiper_ctrl #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n_i,
  input  logic           sclk_i,
  input  logic           dir_i,
  input  logic [1:0]     ds_i,
  input  logic           wp_i,
  input  logic [1:0]     rsel_i,
  input  logic [4*W-1:0] preset_i,
  output logic [4*W-1:0] pos_o,
  output logic           store_stb_o,
  output logic [1:0]     store_idx_o,
  output logic           bus_off_o
);
  localparam int NW = 4;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         cs_q, sclk_q;
  logic [W-1:0] cnt [NW];

  wire [1:0] sel_idx  = {ds_i[1] ^ ds_i[0], ds_i[0]};
  wire       step     = !cs_n_i && sclk_q && !sclk_i;
  wire       release_ = !cs_q && cs_n_i;
  wire       do_store = release_ && sclk_i && wp_i && (rsel_i == 2'b00);

  assign bus_off_o = !cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q        <= 1'b1;
      sclk_q      <= 1'b0;
      store_stb_o <= 1'b0;
      store_idx_o <= 2'b00;
    end else begin
      cs_q        <= cs_n_i;
      sclk_q      <= sclk_i;
      store_stb_o <= do_store;
      if (do_store) store_idx_o <= sel_idx;
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_wiper
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[i] <= preset_i[W*i +: W];
      else if (step && sel_idx == 2'(i)) begin
        if (dir_i && cnt[i] != TOP)
          cnt[i] <= cnt[i] + 1'b1;
        else if (!dir_i && cnt[i] != '0)
          cnt[i] <= cnt[i] - 1'b1;
      end
    end
    assign pos_o[W*i +: W] = cnt[i];

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_i |=> $stable(cnt[i]));
    a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(cnt[i]) == TOP && cnt[i] == '0));
    a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(cnt[i]) == '0 && cnt[i] == TOP));
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[i] != $past(cnt[i])) |->
        (W'(cnt[i] - $past(cnt[i])) == W'(1) || W'($past(cnt[i]) - cnt[i]) == W'(1)));
  end

  a_r7_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb_o |=> !store_stb_o);
  a_r8_store_gated: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb_o |-> ($past(wp_i) && $past(rsel_i) == 2'b00 && $past(sclk_i)));
  a_r10_bus_free_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb_o |-> !bus_off_o);
endmodule

// File: tb/test_updown_wiper_ctrl.sv
`timescale 1ns/1ps
module test_updown_wiper_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b1, dir = 1'b1, wp = 1'b1;
  logic [1:0]  ds = 2'b00, rsel = 2'b00;
  logic [31:0] preset = {8'h80, 8'h01, 8'hFE, 8'h10};
  logic [31:0] pos;
  logic        stb, bus_off;
  logic [1:0]  sidx;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  updown_wiper_ctrl i_updown_wiper_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .dir_i(dir),
    .ds_i(ds), .wp_i(wp), .rsel_i(rsel), .preset_i(preset), .pos_o(pos),
    .store_stb_o(stb), .store_idx_o(sidx), .bus_off_o(bus_off));

  // fields: cs sclk dir ds wp rsel chk_idx exp_val exp_stb
  localparam logic [18:0] VEC [20] = '{
    19'b0_1_1_00_1_00_00_00010000_0,
    19'b0_0_1_00_1_00_00_00010001_0,
    19'b0_1_1_00_1_00_00_00010001_0,
    19'b0_0_1_00_1_00_00_00010010_0,
    19'b0_1_0_00_1_00_00_00010010_0,
    19'b0_0_0_00_1_00_00_00010001_0,
    19'b0_1_0_11_1_00_01_11111110_0,
    19'b0_0_1_11_1_00_01_11111111_0,
    19'b0_1_1_11_1_00_01_11111111_0,
    19'b0_0_1_11_1_00_01_11111111_0,
    19'b0_1_0_10_1_00_10_00000001_0,
    19'b0_0_0_10_1_00_10_00000000_0,
    19'b0_1_0_10_1_00_10_00000000_0,
    19'b0_0_0_10_1_00_10_00000000_0,
    19'b0_1_1_01_1_00_11_10000000_0,
    19'b0_0_1_01_1_00_11_10000001_0,
    19'b1_1_1_01_1_00_11_10000001_1,
    19'b1_1_1_01_1_00_11_10000001_0,
    19'b1_0_1_01_1_00_11_10000001_0,
    19'b1_1_1_01_1_00_11_10000001_0
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic c, logic s, logic d, logic [1:0] sel, logic w, logic [1:0] r);
    cs_n = c; sclk = s; dir = d; ds = sel; wp = w; rsel = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 preset", pos, 32'h8001FE10);
    chk("R1 strobe", {31'b0, stb}, 32'd0);
    chk("R1 bus", {31'b0, bus_off}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 20; k++) begin
      logic [18:0] v;
      v = VEC[k];
      drive(v[18], v[17], v[16], v[15:14], v[13], v[12:11]);
      chk($sformatf("vec %0d position (R2,R3,R4,R5,R6,R11,R12)", k),
          {24'b0, pos[8*v[10:9] +: 8]}, {24'b0, v[8:1]});
      chk($sformatf("vec %0d strobe (R7)", k), {31'b0, stb}, {31'b0, v[0]});
      if (v[0]) chk($sformatf("vec %0d index (R7,R4)", k), {30'b0, sidx}, {30'b0, v[10:9]});
      chk($sformatf("vec %0d bus flag (R10)", k), {31'b0, bus_off}, {31'b0, ~v[18]});
    end
    chk("R4 untouched slices", pos, 32'h8100FF11);

    // R9: release with step clock low
    drive(0, 1, 1, 2'b10, 1, 2'b00);
    drive(0, 0, 1, 2'b10, 1, 2'b00);
    chk("R2 step before low release", {24'b0, pos[23:16]}, 32'h01);
    drive(1, 0, 1, 2'b10, 1, 2'b00);
    chk("R9 no store", {31'b0, stb}, 32'd0);
    chk("R9 position kept", {24'b0, pos[23:16]}, 32'h01);
    drive(1, 1, 1, 2'b10, 1, 2'b00);

    // R8: write protect low, then nonzero register field
    drive(0, 1, 1, 2'b10, 1, 2'b00);
    drive(1, 1, 1, 2'b10, 0, 2'b00);
    chk("R8 wp low", {31'b0, stb}, 32'd0);
    drive(0, 1, 1, 2'b10, 1, 2'b00);
    drive(1, 1, 1, 2'b10, 1, 2'b01);
    chk("R8 rsel nonzero", {31'b0, stb}, 32'd0);

    // R7: store of index 2, strobe lasts one cycle
    drive(0, 1, 1, 2'b10, 1, 2'b00);
    drive(1, 1, 1, 2'b10, 1, 2'b00);
    chk("R7 strobe", {31'b0, stb}, 32'd1);
    chk("R7 index", {30'b0, sidx}, 32'd2);
    drive(1, 1, 1, 2'b10, 1, 2'b00);
    chk("R7 single cycle", {31'b0, stb}, 32'd0);
    chk("R10 standby bus", {31'b0, bus_off}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule